// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block is the per-CPU timer. It raises an interrupt request strobe at an interval that software sets. Software programs an interval count and a time unit through a small word-addressed register port. Every clock, the block adds the unit value to an internal accumulator. When the running total reaches the interval count, the block emits a one-cycle strobe and keeps the remainder. Each strobe carries an interrupt line number that software chooses. The timer keeps firing until software clears the enable bit. For one-shot use, software clears the enable as soon as it sees the first strobe.

Next to the periodic engine sits an independent 12-bit countdown. A register write loads it. It then counts down once per clock and stops at zero, and on reaching zero it raises a sticky completion flag. Each CPU instantiates its own copy, so no state is shared between instances.

Top module: `pit_top`

## Requirements
- R1: After reset all registers read zero, `irq_stb_o` and `done_o` are low, and `irq_num_o` is zero.
- R2: Register map and readback, with the word selected by `addr_i[3:2]`:
  - index 0 is control, with the enable at bit 8 and the interrupt number at bits 7:0.
  - index 1 is the interval count (32 bits).
  - index 2 is the time unit (32 bits).
  - index 3 is the countdown, with the count at bits 11:0 and the done flag at bit 16.
  - Bits with no field read zero.
  - A write takes effect at the clock edge where `req_i` and `we_i` are both high.
- R3: While the timer is enabled and the interval count is nonzero, every clock adds the time unit to the accumulator. When the sum is at least the interval count, the strobe is high for the following cycle and the interval count is subtracted. Over K clocks from a cleared accumulator, floor(K·unit/count) strobes appear.
- R4: `irq_num_o` takes the control register's interrupt number at each fire and holds that value between fires.
- R5: A control write with bit 8 clear stops the timer. In that same clock it clears the accumulator and suppresses any strobe. No strobe follows while the timer is disabled.
- R6: An interval count of zero never produces a strobe.
- R7: A write to the interval count or the time unit clears the accumulator and produces no strobe for that clock.
- R8: When the time unit is at least the interval count, the strobe is high on every enabled clock, and any excess remainder is discarded.
- R9: A write to index 3 loads the count and clears done. A nonzero count decrements each clock and holds at zero. Done is set when the count steps from 1 to 0 and stays set until the next index-3 write. Loading zero does not set done.
- R10: `done_o` always equals the countdown done flag.
- R11: Firing repeats at the programmed interval for as long as the enable stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 4 | Byte address; bits 3:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register (combinational) |
| irq_stb_o | output | 1 | One-cycle interrupt request strobe |
| irq_num_o | output | 8 | Interrupt number of the latest fire |
| done_o | output | 1 | Countdown reached zero (sticky) |

## Verification
A wrong accumulator value shows up on `irq_stb_o` within one interval. The strobe arrives early, arrives late, or is missing in the exact cycle the running sum predicts. A per-clock comparison against a behavioural model therefore isolates the fault to a single edge. Errors in the enable, clear-on-write or zero-count handling also show on `irq_stb_o`, at the first clock where a strobe should or should not appear. A corrupt countdown shows on `done_o` one clock too early or too late, and `rdata_o` exposes the count directly as soon as index 3 is addressed.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IRQ_W    = 8;
  localparam int unsigned CD_W     = 12;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned EN_BIT   = 8;
  localparam int unsigned DONE_BIT = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_THR  = 2'd1,
    REG_UNIT = 2'd2,
    REG_CD   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IRQ_W,
  parameter int unsigned CW = CD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] cd_cnt_i,
  input  logic          cd_done_i,
  output logic [DW-1:0] rdata_o,
  output logic          en_o,
  output logic [IW-1:0] irq_o,
  output logic [DW-1:0] thr_o,
  output logic [DW-1:0] unit_o,
  output logic          stop_o,
  output logic          cfg_o,
  output logic          cd_ld_o,
  output logic [CW-1:0] cd_val_o
);
  reg_idx_e idx;
  logic     wr;
  logic     unused_bits;

  assign idx         = reg_idx_e'(addr_i[3:2]);
  assign wr          = req_i & we_i;
  assign unused_bits = ^{addr_i[1:0]};

  // Decoded strobes consumed by the accumulator and countdown
  assign stop_o   = wr && (idx == REG_CTRL) && !wdata_i[EN_BIT];
  assign cfg_o    = wr && ((idx == REG_THR) || (idx == REG_UNIT));
  assign cd_ld_o  = wr && (idx == REG_CD);
  assign cd_val_o = wdata_i[CW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      irq_o  <= '0;
      thr_o  <= '0;
      unit_o <= '0;
    end else if (wr) begin
      unique case (idx)
        REG_CTRL: begin
          en_o  <= wdata_i[EN_BIT];
          irq_o <= wdata_i[IW-1:0];
        end
        REG_THR:  thr_o  <= wdata_i;
        REG_UNIT: unit_o <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      REG_CTRL: begin
        rdata_o[IW-1:0]   = irq_o;
        rdata_o[EN_BIT]   = en_o;
      end
      REG_THR:  rdata_o = thr_o;
      REG_UNIT: rdata_o = unit_o;
      REG_CD: begin
        rdata_o[CW-1:0]   = cd_cnt_i;
        rdata_o[DONE_BIT] = cd_done_i;
      end
      default: rdata_o = '0;
    endcase
  end

  p_stop_clears_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !en_o);
  p_cfg_holds_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o || cd_ld_o) |=> $stable(en_o));
endmodule

// File: rtl/pit_accum.sv
module pit_accum
  import pit_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IRQ_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [IW-1:0] irq_i,
  input  logic [DW-1:0] thr_i,
  input  logic [DW-1:0] unit_i,
  input  logic          stop_i,
  input  logic          cfg_i,
  output logic          stb_o,
  output logic [IW-1:0] irq_num_o
);
  localparam int unsigned SW = DW + 1;

  logic [DW-1:0] acc_q;
  logic [SW-1:0] sum, rem;
  logic          hold, fire;
  logic [DW-1:0] acc_d;

  assign hold = !en_i || stop_i || cfg_i || (thr_i == '0);
  assign sum  = {1'b0, acc_q} + {1'b0, unit_i};
  assign fire = sum >= {1'b0, thr_i};
  assign rem  = sum - {1'b0, thr_i};

  // Remainder beyond one interval is dropped: at most one fire per clock
  always_comb begin
    if (!fire)                      acc_d = sum[DW-1:0];
    else if (rem >= {1'b0, thr_i})  acc_d = '0;
    else                            acc_d = rem[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      stb_o     <= 1'b0;
      irq_num_o <= '0;
    end else if (hold) begin
      acc_q <= '0;
      stb_o <= 1'b0;
    end else begin
      acc_q <= acc_d;
      stb_o <= fire;
      if (fire) irq_num_o <= irq_i;
    end
  end

  p_acc_below_thr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i != '0) |-> (acc_q < thr_i));
  p_acc_zero_when_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));
  p_no_stb_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || stop_i) |=> !stb_o);
  p_zero_thr_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i == '0) |=> !stb_o);
  p_cfg_no_stb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i |=> (!stb_o && acc_q == '0));
  p_fast_unit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stop_i && !cfg_i && thr_i != '0 && unit_i >= thr_i) |=> stb_o);
  p_irq_moves_on_fire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_num_o) |-> stb_o);
endmodule

// File: rtl/pit_cdown.sv
module pit_cdown
  import pit_pkg::*;
#(
  parameter int unsigned CW = CD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [CW-1:0] val_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else if (ld_i) begin
      cnt_o  <= val_i;
      done_o <= 1'b0;
    end else if (cnt_o != '0) begin
      cnt_o <= cnt_o - ONE;
      if (cnt_o == ONE) done_o <= 1'b1;
    end
  end

  p_cd_hold_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !ld_i) |=> (cnt_o == '0));
  p_cd_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0 && !ld_i) |=> (cnt_o == $past(cnt_o) - ONE));
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ld_i) |=> done_o);
  p_load_clears_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> !done_o);
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IRQ_W,
  parameter int unsigned CW = CD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_stb_o,
  output logic [IW-1:0] irq_num_o,
  output logic          done_o
);
  logic          en, stop, cfg, cd_ld;
  logic [IW-1:0] irq;
  logic [DW-1:0] thr, unit;
  logic [CW-1:0] cd_val, cd_cnt;

  pit_regs #(.DW(DW), .IW(IW), .CW(CW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cd_cnt_i (cd_cnt),
    .cd_done_i(done_o),
    .rdata_o,
    .en_o     (en),
    .irq_o    (irq),
    .thr_o    (thr),
    .unit_o   (unit),
    .stop_o   (stop),
    .cfg_o    (cfg),
    .cd_ld_o  (cd_ld),
    .cd_val_o (cd_val)
  );

  pit_accum #(.DW(DW), .IW(IW)) u_accum (
    .clk_i, .rst_ni,
    .en_i     (en),
    .irq_i    (irq),
    .thr_i    (thr),
    .unit_i   (unit),
    .stop_i   (stop),
    .cfg_i    (cfg),
    .stb_o    (irq_stb_o),
    .irq_num_o(irq_num_o)
  );

  pit_cdown #(.CW(CW)) u_cdown (
    .clk_i, .rst_ni,
    .ld_i  (cd_ld),
    .val_i (cd_val),
    .cnt_o (cd_cnt),
    .done_o(done_o)
  );

  p_stb_needs_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stb_o |-> $past(en));
endmodule

// File: tb/pit_top_test.sv
module pit_top_test;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_stb_o, done_o;
  logic [7:0]  irq_num_o;

  int checks = 0, fails = 0, stb_cnt = 0;
  bit mon_en = 1'b0;

  pit_top uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // Behavioural reference state
  bit          m_en, m_stb, m_done;
  logic [7:0]  m_irq, m_irqo;
  longint      m_thr, m_unit, m_acc;
  int          m_cnt;

  always @(posedge clk_i or negedge rst_ni) begin : model
    bit w, stop, cfg;
    int ix;
    longint s;
    if (!rst_ni) begin
      m_en = 0; m_stb = 0; m_done = 0; m_irq = 0; m_irqo = 0;
      m_thr = 0; m_unit = 0; m_acc = 0; m_cnt = 0;
    end else begin
      w    = req_i && we_i;
      ix   = int'(addr_i[3:2]);
      stop = w && ix == 0 && !wdata_i[8];
      cfg  = w && (ix == 1 || ix == 2);
      m_stb = 0;
      if (!m_en || stop || cfg || m_thr == 0) m_acc = 0;
      else begin
        s = m_acc + m_unit;
        if (s >= m_thr) begin
          m_stb = 1; m_irqo = m_irq; s = s - m_thr;
          if (s >= m_thr) s = 0;
        end
        m_acc = s;
      end
      if (w && ix == 3) begin m_cnt = int'(wdata_i[11:0]); m_done = 0; end
      else if (m_cnt != 0) begin if (m_cnt == 1) m_done = 1; m_cnt--; end
      if (w) begin
        case (ix)
          0: begin m_en = wdata_i[8]; m_irq = wdata_i[7:0]; end
          1: m_thr  = longint'(wdata_i);
          2: m_unit = longint'(wdata_i);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input int ix);
    case (ix)
      0: return {23'd0, m_en, m_irq};
      1: return m_thr[31:0];
      2: return m_unit[31:0];
      default: return {15'd0, m_done, 4'd0, m_cnt[11:0]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    #1;
    if (mon_en && rst_ni) begin
      if (irq_stb_o) stb_cnt++;
      chk(irq_stb_o == m_stb, "R3 strobe", irq_stb_o, m_stb);
      chk(irq_num_o == m_irqo, "R4 irq number", irq_num_o, m_irqo);
      chk(done_o == m_done, "R10 done", done_o, m_done);
      chk(rdata_o == exp_rd(int'(addr_i[3:2])), "R2 readback", rdata_o, exp_rd(int'(addr_i[3:2])));
    end
  end

  task automatic wr(input int ix, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 4'(ix << 2); wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd_chk(input int ix, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    addr_i = 4'(ix << 2);
    #2;
    chk(rdata_o == exp, req, rdata_o, exp);
  endtask

  task automatic count_window(input int k, input int exp, input string req);
    stb_cnt = 0;
    repeat (k) @(negedge clk_i);
    #2;
    chk(stb_cnt == exp, req, stb_cnt, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    #2;
    chk(irq_stb_o == 0, "R1 strobe", irq_stb_o, 0);
    chk(irq_num_o == 0, "R1 irq number", irq_num_o, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
    for (int i = 0; i < 4; i++) rd_chk(i, 32'd0, "R1 register");
    mon_en = 1;

    // R2 field masking and readback
    wr(0, 32'hFFFF_FEFF);
    rd_chk(0, 32'h0000_00FF, "R2 ctrl mask");
    wr(1, 32'hDEAD_BEEF);
    rd_chk(1, 32'hDEAD_BEEF, "R2 interval");
    wr(2, 32'h1234_5678);
    rd_chk(2, 32'h1234_5678, "R2 unit");

    // R3 interval 10, unit 3, irq 0x2A
    wr(1, 32'd10); wr(2, 32'd3);
    wr(0, 32'h0000_012A);
    count_window(40, 12, "R3 fire count");
    chk(irq_num_o == 8'h2A, "R4 irq number", irq_num_o, 8'h2A);

    // R7 unit change mid-run clears the accumulator
    wr(2, 32'd5);
    count_window(20, 10, "R7 fire count after reprogram");

    // R4 new irq number on the next fire
    wr(0, 32'h0000_0155);
    repeat (6) @(negedge clk_i);
    #2;
    chk(irq_num_o == 8'h55, "R4 irq update", irq_num_o, 8'h55);

    // R11 periodic continues: interval 4, unit 1
    wr(1, 32'd4); wr(2, 32'd1);
    count_window(40, 10, "R11 periodic count");

    // R5 disable stops firing
    wr(0, 32'h0000_0055);
    count_window(20, 0, "R5 disabled");
    chk(irq_num_o == 8'h55, "R4 irq held", irq_num_o, 8'h55);

    // R8 unit larger than interval
    wr(1, 32'd5); wr(2, 32'd7);
    wr(0, 32'h0000_0101);
    count_window(10, 10, "R8 every cycle");

    // R5 disable in a clock that would fire
    wr(0, 32'h0000_0001);
    count_window(5, 0, "R5 stop suppresses");

    // R6 zero interval never fires
    wr(1, 32'd0); wr(2, 32'd1);
    wr(0, 32'h0000_0101);
    count_window(20, 0, "R6 zero interval");
    wr(0, 32'h0000_0000);

    // R9 countdown
    wr(3, 32'd5);
    repeat (4) @(negedge clk_i);
    #2;
    chk(done_o == 0, "R9 not yet done", done_o, 0);
    @(negedge clk_i);
    #2;
    chk(done_o == 1, "R9 done at zero", done_o, 1);
    repeat (5) @(negedge clk_i);
    rd_chk(3, 32'h0001_0000, "R9 sticky and holds zero");
    wr(3, 32'd0);
    repeat (4) @(negedge clk_i);
    #2;
    chk(done_o == 0, "R9 load zero clears", done_o, 0);
    wr(3, 32'd4095);
    repeat (10) @(negedge clk_i);
    rd_chk(3, 32'd4084, "R9 decrement");

    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule